// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery

This block keeps the fault-confinement state of a CAN controller. The protocol engine sends single-cycle strobes when a frame is sent or received without fault and when it sees an error while sending or receiving. The block turns these strobes into a transmit error count and a receive error count. From the two counts it derives three status flags: a warning flag, an error-passive flag and a bus-off flag.

If the transmit count is pushed past its 8-bit range, the controller goes bus-off. The block then forces the controller into reset mode and holds it there until the host writes reset mode back to 0. After that write, it watches the sampled bus level on each bit-time strobe. It leaves bus-off only after enough idle periods have passed. On leaving, it clears both counters and the warning flag. A one-cycle error interrupt, gated by an enable, marks each change of the warning flag, the entry into bus-off and the recovery.

Top module: `can_fault_guard`

## Requirements
- R1: A transmit error strobe adds 8 to the transmit count. A transmit success strobe subtracts 1 and stops at 0. If both strobes come in the same cycle, the error wins.
- R2: A receive error strobe adds 1 to the receive count and stops at 255. A receive success strobe subtracts 1 and stops at 0. If both strobes come in the same cycle, the error wins.
- R3: A transmit error while the transmit count is 248 or more sets bus-off and sets the transmit count to 255. In the same cycle it forces reset mode to 1, even if the host writes reset mode in that cycle.
- R4: While bus-off is 1, the four event strobes have no effect on either count.
- R5: While bus-off and reset mode are both 1, bus-off stays 1 and no bus activity is counted toward recovery.
- R6: Recovery starts once bus-off is 1 and reset mode is 0. An idle period is 11 consecutive bit strobes with the bus bit at 1 (1 = recessive). A 0 on the bus restarts the current period but keeps the periods already completed. On the clock edge that ends the 128th period, bus-off clears and both counts become 0.
- R7: The warning flag is 1 when either count is 96 or more. It updates on the same edge as the counts.
- R8: The error-passive flag is 1 when either count is 128 or more and bus-off is 0.
- R9: The error interrupt is a one-cycle pulse that follows the counts by no cycles. It fires, if the enable is 1, on a change of the warning flag, on bus-off entry or on recovery. It never fires when the enable is 0.
- R10: After reset, all outputs are 0. A host write (write strobe with a value) loads reset mode, except in a cycle where bus-off is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_evt | input | 1 | Error seen while transmitting (pulse) |
| rx_err_evt | input | 1 | Error seen while receiving (pulse) |
| tx_ok_evt | input | 1 | Frame sent without error (pulse) |
| rx_ok_evt | input | 1 | Frame received without error (pulse) |
| bit_tick | input | 1 | Bit-time strobe |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| host_wr | input | 1 | Host write strobe for reset mode |
| host_val | input | 1 | Reset-mode value written by the host |
| irq_en | input | 1 | Error interrupt enable |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive flag |
| busoff_o | output | 1 | Bus-off flag |
| rst_mode_o | output | 1 | Reset mode |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
The assertions expect strobes that are synchronous to clk and settled before each edge. Event strobes may arrive in any combination in a cycle, including error and success together. The stimulus is built to meet these conditions: every input changes only on the falling edge, and events are drawn at random rates high enough to drive the transmit count into bus-off again and again. The bus bit is recessive most of the time but carries a few dominant bits, so full idle periods are completed and interrupted periods also occur. The host release is delayed at random, and stray host writes of 1 during recovery restart the idle count.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int CNT_W   = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // true when adding step would leave the counter range
  function automatic logic fc_exceeds(cnt_t c, int step);
    return (int'(c) + step) > CNT_MAX;
  endfunction

  function automatic cnt_t fc_add_sat(cnt_t c, int step);
    if ((int'(c) + step) > CNT_MAX) return cnt_t'(CNT_MAX);
    return cnt_t'(int'(c) + step);
  endfunction

  function automatic cnt_t fc_dec_sat(cnt_t c);
    if (c == '0) return '0;
    return c - cnt_t'(1);
  endfunction

  function automatic logic fc_either_ge(cnt_t a, cnt_t b, int lim);
    return (int'(a) >= lim) || (int'(b) >= lim);
  endfunction
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters
  import can_fc_pkg::*;
#(
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_err,
  input  logic rx_err,
  input  logic tx_ok,
  input  logic rx_ok,
  input  logic freeze,
  input  logic clear,
  output cnt_t tec_q,
  output cnt_t rec_q,
  output cnt_t tec_d,
  output cnt_t rec_d,
  output logic tx_over
);
  always_comb begin
    tec_d   = tec_q;
    rec_d   = rec_q;
    tx_over = 1'b0;
    if (clear) begin
      tec_d = '0;
      rec_d = '0;
    end else if (!freeze) begin
      if (tx_err) begin
        if (fc_exceeds(tec_q, TX_STEP)) begin
          tx_over = 1'b1;
          tec_d   = cnt_t'(CNT_MAX);
        end else begin
          tec_d = fc_add_sat(tec_q, TX_STEP);
        end
      end else if (tx_ok) begin
        tec_d = fc_dec_sat(tec_q);
      end
      if (rx_err)     rec_d = fc_add_sat(rec_q, RX_STEP);
      else if (rx_ok) rec_d = fc_dec_sat(rec_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  p_tx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !freeze && !clear && !fc_exceeds(tec_q, TX_STEP))
      |=> (int'(tec_q) == int'($past(tec_q)) + TX_STEP));

  p_rx_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !freeze && !clear && rec_q == cnt_t'(CNT_MAX)) |=> (rec_q == cnt_t'(CNT_MAX)));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clear) |=> ($stable(tec_q) && $stable(rec_q)));
endmodule

// File: rtl/can_fc_idle.sv
module can_fc_idle #(
  parameter int RUN_BITS = 11,
  parameter int SEQS     = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_tick,
  input  logic bus_bit,
  output logic done
);
  localparam int RUN_W = $clog2(RUN_BITS + 1);
  localparam int OCC_W = $clog2(SEQS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_BITS - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(SEQS - 1);

  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;
  logic             run_end;

  assign run_end = enable && bit_tick && bus_bit && (run_q == RUN_LAST);
  assign done    = run_end && (occ_q == OCC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!enable || done) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_tick) begin
      if (!bus_bit) begin
        run_q <= '0;
      end else if (run_end) begin
        run_q <= '0;
        occ_q <= occ_q + OCC_W'(1);
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  p_done_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (enable && bit_tick && bus_bit));

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_q) < SEQS) && (int'(run_q) < RUN_BITS));
endmodule

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
#(
  parameter int WARN_LIM = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_over,
  input  logic recover,
  input  logic host_wr,
  input  logic host_val,
  input  logic irq_en,
  input  cnt_t tec_d,
  input  cnt_t rec_d,
  output logic busoff_q,
  output logic rst_mode_q,
  output logic warn_q,
  output logic irq_q
);
  logic warn_d;
  logic warn_flip;

  assign warn_d    = fc_either_ge(tec_d, rec_d, WARN_LIM);
  assign warn_flip = warn_d != warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busoff_q   <= 1'b0;
      rst_mode_q <= 1'b0;
      warn_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (tx_over)      busoff_q <= 1'b1;
      else if (recover) busoff_q <= 1'b0;
      if (tx_over)      rst_mode_q <= 1'b1;
      else if (host_wr) rst_mode_q <= host_val;
      warn_q <= warn_d;
      irq_q  <= irq_en && (warn_flip || tx_over || recover);
    end
  end

  p_enter_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff_q) |-> rst_mode_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_q && rst_mode_q) |=> busoff_q);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(irq_en));
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
  import can_fc_pkg::*;
#(
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int RUN_BITS    = 11,
  parameter int IDLE_SEQS   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_evt,
  input  logic             rx_err_evt,
  input  logic             tx_ok_evt,
  input  logic             rx_ok_evt,
  input  logic             bit_tick,
  input  logic             bus_bit,
  input  logic             host_wr,
  input  logic             host_val,
  input  logic             irq_en,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic             rst_mode_o,
  output logic             err_irq_o
);
  cnt_t tec_q, rec_q, tec_d, rec_d;
  logic tx_over;
  logic recover;
  logic idle_en;
  logic busoff_q, rst_mode_q;

  assign idle_en = busoff_q && !rst_mode_q;

  can_fc_counters #(.TX_STEP(TX_STEP), .RX_STEP(RX_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tx_err(tx_err_evt), .rx_err(rx_err_evt),
    .tx_ok(tx_ok_evt), .rx_ok(rx_ok_evt),
    .freeze(busoff_q), .clear(recover),
    .tec_q(tec_q), .rec_q(rec_q), .tec_d(tec_d), .rec_d(rec_d),
    .tx_over(tx_over)
  );

  can_fc_idle #(.RUN_BITS(RUN_BITS), .SEQS(IDLE_SEQS)) u_idle (
    .clk(clk), .rst_n(rst_n), .enable(idle_en),
    .bit_tick(bit_tick), .bus_bit(bus_bit), .done(recover)
  );

  can_fc_ctrl #(.WARN_LIM(WARN_LIM)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .tx_over(tx_over), .recover(recover),
    .host_wr(host_wr), .host_val(host_val), .irq_en(irq_en),
    .tec_d(tec_d), .rec_d(rec_d),
    .busoff_q(busoff_q), .rst_mode_q(rst_mode_q),
    .warn_q(warn_o), .irq_q(err_irq_o)
  );

  assign tec_o      = tec_q;
  assign rec_o      = rec_q;
  assign busoff_o   = busoff_q;
  assign rst_mode_o = rst_mode_q;
  assign passive_o  = !busoff_q && fc_either_ge(tec_q, rec_q, PASSIVE_LIM);

  p_recover_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busoff_q) |-> (tec_q == '0 && rec_q == '0 && !warn_o));

  p_passive_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_o |-> !passive_o);
endmodule

// File: tb/can_fault_guard_bench.sv
`timescale 1ns/1ps
module can_fault_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err_evt = 0, rx_err_evt = 0, tx_ok_evt = 0, rx_ok_evt = 0;
  logic bit_tick = 0, bus_bit = 1, host_wr = 0, host_val = 0, irq_en = 0;
  logic [7:0] tec_o, rec_o;
  logic warn_o, passive_o, busoff_o, rst_mode_o, err_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int m_tec = 0, m_rec = 0, m_run = 0, m_occ = 0;
  bit m_bo = 0, m_rm = 0, m_warn = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  can_fault_guard u_can_fault_guard (
    .clk(clk), .rst_n(rst_n),
    .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt),
    .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt),
    .bit_tick(bit_tick), .bus_bit(bus_bit),
    .host_wr(host_wr), .host_val(host_val), .irq_en(irq_en),
    .tec_o(tec_o), .rec_o(rec_o), .warn_o(warn_o), .passive_o(passive_o),
    .busoff_o(busoff_o), .rst_mode_o(rst_mode_o), .err_irq_o(err_irq_o)
  );

  function automatic int up_to(int v, int top);
    return (v > top) ? top : v;
  endfunction

  function automatic int down_one(int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance the reference by one clock edge using the current inputs
  task automatic model_edge();
    bit enter = 0, done = 0, counting;
    int nt = m_tec, nr = m_rec;
    counting = m_bo && !m_rm;
    if (counting && bit_tick) begin
      if (bus_bit) begin
        m_run++;
        if (m_run == 11) begin
          m_run = 0;
          m_occ++;
          if (m_occ == 128) done = 1;
        end
      end else m_run = 0;
    end
    if (done) begin
      nt = 0; nr = 0;
    end else if (!m_bo) begin
      if (tx_err_evt) begin
        if (m_tec + 8 > 255) begin enter = 1; nt = 255; end
        else nt = m_tec + 8;
      end else if (tx_ok_evt) nt = down_one(m_tec);
      if (rx_err_evt) nr = up_to(m_rec + 1, 255);
      else if (rx_ok_evt) nr = down_one(m_rec);
    end
    if (!counting || done) begin m_run = 0; m_occ = 0; end
    m_irq = irq_en && (((nt >= 96) || (nr >= 96)) != m_warn || enter || done);
    m_warn = (nt >= 96) || (nr >= 96);
    if (enter) m_bo = 1; else if (done) m_bo = 0;
    if (enter) m_rm = 1; else if (host_wr) m_rm = host_val;
    m_tec = nt; m_rec = nr;
  endtask

  task automatic compare_all();
    check("R1/R3/R4/R6 tec", int'(tec_o), m_tec);
    check("R2/R4/R6 rec", int'(rec_o), m_rec);
    check("R3/R5/R6 busoff", int'(busoff_o), int'(m_bo));
    check("R3/R10 rst_mode", int'(rst_mode_o), int'(m_rm));
    check("R7 warn", int'(warn_o), int'(m_warn));
    check("R8 passive", int'(passive_o), int'(!m_bo && (m_tec >= 128 || m_rec >= 128)));
    check("R9 irq", int'(err_irq_o), int'(m_irq));
  endtask

  // inputs are already set at a falling edge; run one clock and compare
  task automatic cycle();
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    tx_err_evt = 0; rx_err_evt = 0; tx_ok_evt = 0; rx_ok_evt = 0;
    bit_tick = 0; bus_bit = 1; host_wr = 0; host_val = 0;
  endtask

  task automatic recessive_ticks(int n);
    for (int i = 0; i < n; i++) begin
      idle_inputs(); bit_tick = 1; bus_bit = 1; cycle();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 reset tec", int'(tec_o), 0);
    check("R10 reset flags", int'({warn_o, passive_o, busoff_o, rst_mode_o, err_irq_o}), 0);
    compare_all();

    // directed: R1/R2 saturation at zero, error beats success
    irq_en = 1;
    idle_inputs(); tx_ok_evt = 1; rx_ok_evt = 1; cycle();
    check("R1 tec floor", int'(tec_o), 0);
    idle_inputs(); tx_err_evt = 1; tx_ok_evt = 1; rx_err_evt = 1; rx_ok_evt = 1; cycle();
    check("R1 tx error wins", int'(tec_o), 8);
    check("R2 rx error wins", int'(rec_o), 1);

    // R10 host write of reset mode
    idle_inputs(); host_wr = 1; host_val = 1; cycle();
    check("R10 host set", int'(rst_mode_o), 1);
    idle_inputs(); host_wr = 1; host_val = 0; cycle();

    // drive to bus-off with a host write 0 in the entry cycle (R3)
    for (int i = 0; i < 30; i++) begin idle_inputs(); tx_err_evt = 1; cycle(); end
    check("R3 before entry", int'(busoff_o), 0);
    idle_inputs(); tx_err_evt = 1; host_wr = 1; host_val = 0; cycle();
    check("R3 entry busoff", int'(busoff_o), 1);
    check("R3 entry rst_mode", int'(rst_mode_o), 1);
    check("R3 entry tec", int'(tec_o), 255);
    check("R9 entry irq", int'(err_irq_o), 1);

    // R4: events ignored while bus-off
    idle_inputs(); tx_ok_evt = 1; rx_err_evt = 1; cycle();
    check("R4 tec frozen", int'(tec_o), 255);
    check("R4 rec frozen", int'(rec_o), 1);

    // R5: idle bits ignored while in reset mode
    recessive_ticks(1500);
    check("R5 still busoff", int'(busoff_o), 1);

    // R6: release, a broken run, then exactly 128 x 11 recessive bits
    idle_inputs(); host_wr = 1; host_val = 0; cycle();
    recessive_ticks(10);
    idle_inputs(); bit_tick = 1; bus_bit = 0; cycle();
    recessive_ticks(1407);
    check("R6 one bit short", int'(busoff_o), 1);
    recessive_ticks(1);
    check("R6 recovered", int'(busoff_o), 0);
    check("R6 counts cleared", int'(tec_o) + int'(rec_o), 0);
    check("R9 recovery irq", int'(err_irq_o), 1);

    // constrained random
    for (int c = 0; c < 60000; c++) begin
      int r;
      idle_inputs();
      tx_err_evt = ($urandom % 100) < 22;
      tx_ok_evt  = ($urandom % 100) < 12;
      rx_err_evt = ($urandom % 100) < 25;
      rx_ok_evt  = ($urandom % 100) < 20;
      bit_tick   = ($urandom % 2) == 1;
      bus_bit    = ($urandom % 100) >= 2;
      irq_en     = ($urandom % 8) != 0;
      r = $urandom % 1000;
      if (m_bo && m_rm && r < 20) begin host_wr = 1; host_val = 0; end
      else if (r < 2) begin host_wr = 1; host_val = 1; end
      else if (r < 6) begin host_wr = 1; host_val = 0; end
      cycle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule